// File: doc/BRIEF.md
# Boundary-Scan Data Register with Mixed Pin Cells

This block is the serial boundary-scan data register for a set of I/O pins. Each pin appears in the chain as a small group of scan bits, and the number of bits depends on the kind of pin. A bidirectional pin or an output-only pin has three bits: the pad input value, the core's output value and the core's output enable. An input-only pin has only its pad input bit. Pins that are not bonded still keep their place in the chain. An external TAP controller supplies the capture, shift and update strobes and an EXTEST mode flag. All scan activity runs on TCK.

On a capture strobe, every bit in the chain loads its pin or core value on the same rising edge. During shift, the chain moves one place toward TDO on each rising edge, and TDI enters at the far end. An update strobe copies the output and enable bits into parallel latches on the falling edge of TCK. While EXTEST is set, those latches drive the pads. Otherwise the core values go to the pads unchanged.

A single packed parameter gives each pin's kind, in order of distance from TDO. The chain length and the position of each pin's group are computed from that parameter at elaboration.

Top module: `bsr_chain`

## Requirements
- R1: The chain length is three bits for each bidirectional or output-only pin plus one bit for each input-only pin. Pin 0's group is nearest TDO, and higher-numbered pins follow toward TDI. Each pin has a 2-bit kind code in `PIN_KINDS[2i+1:2i]`: 0 is bidirectional, 1 is input-only, 2 is output-only.
- R2: Inside a three-bit group at chain offset b, bit b holds the pad input, bit b+1 holds the core output and bit b+2 holds the core output enable. The input bit is the one nearest TDO.
- R3: An input-only pin has a single bit in the chain, which holds its pad input. Its `pad_out` and `pad_oe` stay 0 in every mode.
- R4: A rising TCK edge with `capture_dr` high loads every chain bit from `pad_in`, `core_out` and `core_oe` as they stand at that edge.
- R5: A rising TCK edge with `shift_dr` high and `capture_dr` low moves the chain one bit toward TDO and loads `tdi` into the last bit. `tdo` always shows chain bit 0.
- R6: The output and enable latches load from their chain bits on a falling TCK edge with `update_dr` high. At all other times they hold, including while the chain shifts.
- R7: When `extest` is 1, `pad_out` and `pad_oe` of bidirectional and output-only pins come from the latches. When `extest` is 0, they equal `core_out` and `core_oe`.
- R8: When `trst_n` is low, the chain and all latches clear at once, without waiting for a clock edge.
- R9: When `capture_dr` and `shift_dr` are both high, the edge performs a capture and does not shift.
- R10: When neither `capture_dr` nor `shift_dr` is high, the chain keeps its contents across rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data entering the chain |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift enable from the TAP controller |
| update_dr | input | 1 | Update strobe, acted on at the falling edge |
| extest | input | 1 | Pads are driven from the update latches when 1 |
| tdo | output | 1 | Serial data leaving the chain (chain bit 0) |
| pad_in | input | N_PINS | Values seen on the pads |
| core_out | input | N_PINS | Output values from the core logic |
| core_oe | input | N_PINS | Output enables from the core logic |
| pad_out | output | N_PINS | Output values driven to the pads |
| pad_oe | output | N_PINS | Output enables driven to the pads |

## Verification
The bench builds the block with four pins. Pin 0 and pin 3 are bidirectional, pin 1 is input-only and pin 2 is output-only, which gives a 10-bit chain. This mix puts a one-bit group between two three-bit groups, so any error in group offsets or bit order inside a group shows up in the shifted stream. The bench also checks that the latches of the output-only pin drive its pad while the input-only pin stays undriven. The stream is shifted four bits past the chain length, so the bench also sees the first TDI bits arrive at TDO.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    PIN_BIDIR  = 2'd0,
    PIN_INPUT  = 2'd1,
    PIN_OUTPUT = 2'd2,
    PIN_RSVD   = 2'd3
  } pin_kind_e;

  // Upper bound on pins that the offset arithmetic walks over.
  localparam int MAX_PINS = 32;

  // Scan bits contributed by one pin of the given kind.
  function automatic int cell_width(logic [1:0] kind);
    return (kind == PIN_INPUT) ? 1 : 3;
  endfunction

  // Chain position of pin idx's first (TDO-side) bit; idx = pin count gives the length.
  function automatic int group_offset(logic [2*MAX_PINS-1:0] kinds, int idx);
    int acc;
    acc = 0;
    for (int j = 0; j < MAX_PINS; j++) begin
      if (j < idx) acc += cell_width(kinds[2*j +: 2]);
    end
    return acc;
  endfunction

endpackage

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
#(
  parameter logic [1:0] KIND = PIN_BIDIR,
  localparam int W = cell_width(KIND)
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         cap_evt,
  input  logic         shf_evt,
  input  logic         ser_in,
  input  logic [W-1:0] cap_d,
  output logic [W-1:0] bits_q,
  output logic         ser_out
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      bits_q <= '0;
        else if (cap_evt) bits_q <= cap_d;
        else if (shf_evt) bits_q <= ser_in;
      end
    end else begin : g_multi
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      bits_q <= '0;
        else if (cap_evt) bits_q <= cap_d;
        else if (shf_evt) bits_q <= {ser_in, bits_q[W-1:1]};
      end
    end
  endgenerate

  assign ser_out = bits_q[0];

  // R4: all bits of the group take the values present at the capture edge
  assert_capture_loads_R4: assert property (@(posedge tck) disable iff (!trst_n)
    cap_evt |=> bits_q == $past(cap_d));

endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage (
  input  logic tck,
  input  logic trst_n,
  input  logic upd_evt,
  input  logic extest,
  input  logic scan_out_bit,
  input  logic scan_oe_bit,
  input  logic core_out,
  input  logic core_oe,
  output logic pad_out,
  output logic pad_oe
);

  logic lat_out;
  logic lat_oe;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      lat_out <= 1'b0;
      lat_oe  <= 1'b0;
    end else if (upd_evt) begin
      lat_out <= scan_out_bit;
      lat_oe  <= scan_oe_bit;
    end
  end

  assign pad_out = extest ? lat_out : core_out;
  assign pad_oe  = extest ? lat_oe  : core_oe;

  // R6: latches only move on an update strobe
  assert_latch_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
    !upd_evt |=> $stable({lat_oe, lat_out}));

  // R6: an update copies the scan bits seen at that falling edge
  assert_latch_load_R6: assert property (@(negedge tck) disable iff (!trst_n)
    upd_evt |=> {lat_oe, lat_out} == $past({scan_oe_bit, scan_out_bit}));

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int                 N_PINS    = 6,
  parameter logic [2*N_PINS-1:0] PIN_KINDS = 12'b00_01_00_10_01_00
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              extest,
  output logic              tdo,
  input  logic [N_PINS-1:0] pad_in,
  input  logic [N_PINS-1:0] core_out,
  input  logic [N_PINS-1:0] core_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe
);

  localparam logic [2*MAX_PINS-1:0] KINDS_W   = (2*MAX_PINS)'(PIN_KINDS);
  localparam int                    CHAIN_LEN = group_offset(KINDS_W, N_PINS);

  // Named events for the assertions.
  logic cap_evt;
  logic shf_evt;
  logic upd_evt;
  assign cap_evt = capture_dr;
  assign shf_evt = shift_dr & ~capture_dr;
  assign upd_evt = update_dr;

  logic [N_PINS:0]      ser;
  logic [CHAIN_LEN-1:0] chain_q;

  assign ser[N_PINS] = tdi;
  assign tdo         = ser[0];

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    localparam logic [1:0] KIND = PIN_KINDS[2*i +: 2];
    localparam int         W    = cell_width(KIND);
    localparam int         OFF  = group_offset(KINDS_W, i);

    logic [W-1:0] cap_d;
    logic [W-1:0] bits_q;

    bsr_cell #(.KIND(KIND)) u_cell (
      .tck     (tck),
      .trst_n  (trst_n),
      .cap_evt (cap_evt),
      .shf_evt (shf_evt),
      .ser_in  (ser[i+1]),
      .cap_d   (cap_d),
      .bits_q  (bits_q),
      .ser_out (ser[i])
    );

    assign chain_q[OFF +: W] = bits_q;

    if (W == 1) begin : g_in_only
      logic unused_core;
      assign cap_d       = pad_in[i];
      assign pad_out[i]  = 1'b0;
      assign pad_oe[i]   = 1'b0;
      assign unused_core = core_out[i] ^ core_oe[i];
    end else begin : g_drive
      assign cap_d = {core_oe[i], core_out[i], pad_in[i]};
      bsr_out_stage u_out (
        .tck          (tck),
        .trst_n       (trst_n),
        .upd_evt      (upd_evt),
        .extest       (extest),
        .scan_out_bit (bits_q[1]),
        .scan_oe_bit  (bits_q[2]),
        .core_out     (core_out[i]),
        .core_oe      (core_oe[i]),
        .pad_out      (pad_out[i]),
        .pad_oe       (pad_oe[i])
      );
    end
  end

  // R5: one step toward TDO with TDI entering the far end
  assert_shift_step_R5: assert property (@(posedge tck) disable iff (!trst_n)
    shf_evt |=> chain_q == {$past(tdi), $past(chain_q[CHAIN_LEN-1:1])});

  // R9: capture wins over shift; pin 0's input bit is chain bit 0
  assert_capture_wins_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && shift_dr) |=> tdo == $past(pad_in[0]));

  // R10: idle edges leave the chain alone
  assert_idle_hold_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr) |=> $stable(chain_q));

endmodule

// File: tb/tb_bsr_chain.sv
`timescale 1ns/1ps
module tb_bsr_chain;

  localparam int          N     = 4;
  localparam logic [7:0]  KINDS = 8'b00_10_01_00; // pin3 bidir, pin2 out-only, pin1 in-only, pin0 bidir
  localparam int          LEN   = 10;

  logic tck = 1'b0;
  logic trst_n, tdi, capture_dr, shift_dr, update_dr, extest, tdo;
  logic [N-1:0] pad_in, core_out, core_oe, pad_out, pad_oe;

  always #2.5 tck = ~tck;

  bsr_chain #(.N_PINS(N), .PIN_KINDS(KINDS)) dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .extest(extest), .tdo(tdo),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [LEN-1:0] m;
  logic q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R1/R2/R3: layout for this pin mix, written out by position
  function automatic logic [LEN-1:0] cap_model(logic [N-1:0] pi, logic [N-1:0] co, logic [N-1:0] ce);
    logic [LEN-1:0] v;
    v[0] = pi[0]; v[1] = co[0]; v[2] = ce[0];
    v[3] = pi[1];
    v[4] = pi[2]; v[5] = co[2]; v[6] = ce[2];
    v[7] = pi[3]; v[8] = co[3]; v[9] = ce[3];
    return v;
  endfunction

  task automatic tick();
    @(posedge tck);
    #3;
  endtask

  task automatic do_capture(logic with_shift);
    capture_dr = 1'b1;
    shift_dr   = with_shift;
    tick();
    capture_dr = 1'b0;
    shift_dr   = 1'b0;
    m = cap_model(pad_in, core_out, core_oe);
  endtask

  // Driver: pushes the expected TDO bit for this shift into the scoreboard.
  task automatic shift_one(logic b);
    tdi      = b;
    shift_dr = 1'b1;
    m        = {b, m[LEN-1:1]};
    q.push_back(m[0]);
    tick();
    shift_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    tick();
    update_dr = 1'b0;
  endtask

  // Monitor: pops one expectation per shift edge (R5, with R1/R2/R3 through layout).
  always @(posedge tck) begin
    if (shift_dr && !capture_dr && trst_n) begin
      #2;
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5: actual %0b expected none (scoreboard empty)", tdo);
      end else begin
        logic e;
        e = q.pop_front();
        check("R5 shifted tdo", {31'd0, tdo}, {31'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    trst_n = 1'b0; tdi = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    extest = 1'b1; pad_in = 4'b0000; core_out = 4'b1111; core_oe = 4'b1111;
    m = '0;
    tick(); tick();
    // R8: reset state
    check("R8 tdo in reset", {31'd0, tdo}, 32'd0);
    check("R8 pad_out extest in reset", {28'd0, pad_out}, 32'd0);
    check("R8 pad_oe extest in reset", {28'd0, pad_oe}, 32'd0);
    extest = 1'b0;
    #1;
    // R7 / R3: pass-through, input-only pin 1 never driven
    check("R7 pad_out passthrough", {28'd0, pad_out}, {28'd0, core_out & 4'b1101});
    check("R3 pad_oe passthrough", {28'd0, pad_oe}, {28'd0, core_oe & 4'b1101});
    trst_n = 1'b1;
    tick();

    // Pattern A: capture then shift past the chain length (R1, R2, R3, R4, R5)
    pad_in = 4'b0101; core_out = 4'b0011; core_oe = 4'b1001;
    do_capture(1'b0);
    check("R4 tdo after capture", {31'd0, tdo}, {31'd0, m[0]});
    for (int k = 0; k < LEN + 4; k++) shift_one(k[0] ^ k[2]);

    // Pattern B: capture and shift together -> capture (R9)
    pad_in = 4'b1010; core_out = 4'b1100; core_oe = 4'b0110;
    do_capture(1'b1);
    check("R9 capture over shift", {31'd0, tdo}, {31'd0, m[0]});
    // R10: idle edges hold the chain
    pad_in = 4'b0101;
    for (int k = 0; k < 3; k++) tick();
    check("R10 hold tdo", {31'd0, tdo}, {31'd0, m[0]});
    for (int k = 0; k < LEN; k++) shift_one(1'b0);

    // Load a pattern, update, drive pads (R6, R7)
    for (int k = 0; k < LEN; k++) shift_one((k % 3) == 1);
    do_update();
    extest = 1'b1;
    core_out = 4'b0000; core_oe = 4'b0000;
    #1;
    check("R7 extest pad_out", {28'd0, pad_out}, {28'd0, m[8], m[5], 1'b0, m[1]});
    check("R7 extest pad_oe", {28'd0, pad_oe}, {28'd0, m[9], m[6], 1'b0, m[2]});
    begin
      logic [N-1:0] po, pe;
      po = pad_out; pe = pad_oe;
      // R6: shifting without update leaves the latches alone
      for (int k = 0; k < LEN; k++) shift_one(k[0]);
      check("R6 pad_out held during shift", {28'd0, pad_out}, {28'd0, po});
      check("R6 pad_oe held during shift", {28'd0, pad_oe}, {28'd0, pe});
    end
    extest = 1'b0; core_out = 4'b1011; core_oe = 4'b0111;
    #1;
    check("R7 back to core pad_out", {28'd0, pad_out}, {28'd0, core_out & 4'b1101});
    check("R7 back to core pad_oe", {28'd0, pad_oe}, {28'd0, core_oe & 4'b1101});
    do_update();
    extest = 1'b1;
    #1;
    check("R6 second update pad_out", {28'd0, pad_out}, {28'd0, m[8], m[5], 1'b0, m[1]});
    check("R6 second update pad_oe", {28'd0, pad_oe}, {28'd0, m[9], m[6], 1'b0, m[2]});

    // R8: asynchronous clear away from any edge
    pad_in = 4'b1111; core_out = 4'b1111; core_oe = 4'b1111;
    do_capture(1'b0);
    #0.5;
    trst_n = 1'b0;
    #0.5;
    check("R8 async tdo", {31'd0, tdo}, 32'd0);
    check("R8 async pad_out", {28'd0, pad_out}, 32'd0);
    check("R8 async pad_oe", {28'd0, pad_oe}, 32'd0);
    m = '0;
    tick();
    trst_n = 1'b1;
    tick();
    for (int k = 0; k < LEN; k++) shift_one(1'b1);
    check("R5 scoreboard drained", q.size(), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule